// File: doc/BRIEF.md
# TMDS Lane Period Sequencer

This block decides, on every TMDS character clock, what each of the three TMDS data lanes carries. When there is nothing to send, each lane sends a 10-bit control character. Lane 0 carries the two sync bits, and lanes 1 and 2 carry the four period-announcement bits. A level request for video or for a data island starts an eight-clock announcement preamble. Two guard-band clocks follow the preamble. Then comes either pass-through of already-encoded video characters, or TERC4-coded packet nibbles.

The sequencer enforces the period framing itself. A data island always runs for a whole number of 32-clock packets and closes with a two-clock trailing guard band. A video period closes at once, with no trailing guard band. Neither kind of period can follow another without at least one plain control clock between them. The packet content, its error-correction bits and the video encoder all sit upstream. This block only places their symbols.

All three lane outputs are registered. The character for a clock appears one clock after the inputs that produced it are sampled.

Top module: `tmds_period_seq`

## Requirements
- R1: While `rst` is high, and in the clock after it, all three lanes output 1101010100.
- R2: In a plain control clock, lane 0 sends the control code of {vsync,hsync}, with vsync as the high bit, and lanes 1 and 2 send code 00. The control codes are 00=1101010100, 01=0010101011, 10=0101010100 and 11=1010101011.
- R3: A request seen in a control clock starts a preamble of exactly 8 clocks. During the preamble lane 1 sends code 01. Lane 2 sends code 00 before video and code 01 before an island. Lane 0 keeps sending the sync control code.
- R4: The preamble before video is followed by exactly 2 guard clocks: 1011001100 on lanes 0 and 2, and 0100110011 on lane 1.
- R5: After the video guard, each lane outputs the video symbol it was given one clock earlier. There is at least one video clock, and video continues while `vid_en` is sampled high.
- R6: The clock in which `vid_en` is sampled low in video is already a plain control clock, so video has no trailing guard. At least one plain control clock (all announcement bits 0) comes before every preamble.
- R7: When both requests are high in a control clock, video wins. `isl_en` has no effect during a video period.
- R8: An island has 2 leading and 2 trailing guard clocks. In these clocks lanes 1 and 2 send 0100110011 and lane 0 sends TERC4 of {1,1,vsync,hsync}.
- R9: In island packet clocks, lane 0 sends TERC4 of {b3,header,vsync,hsync}, where b3 is 0 on the first clock of each packet and 1 otherwise. Lanes 1 and 2 send TERC4 of their nibbles. TERC4: 0000=1010011100, 0001=1001100011, 0010=1011100100, 0011=1011100010, 0100=0101110001, 0101=0100011110, 0110=0110001110, 0111=0100111100, 1000=1011001100, 1001=0100111001, 1010=0110011100, 1011=1011000110, 1100=1010001110, 1101=1001110001, 1110=0101100011, 1111=1011000011.
- R10: An island is made of whole 32-clock packets. `isl_en` is sampled only in the last clock of a packet, to decide whether another packet follows.
- R11: The clock after the trailing island guard is a plain control clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TMDS character clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_en | input | 1 | Request for, and continuation of, a video period |
| isl_en | input | 1 | Request for a data island; continuation is sampled at packet ends |
| hsync | input | 1 | Horizontal sync bit |
| vsync | input | 1 | Vertical sync bit |
| vid_sym0 | input | 10 | Encoded video character for lane 0 |
| vid_sym1 | input | 10 | Encoded video character for lane 1 |
| vid_sym2 | input | 10 | Encoded video character for lane 2 |
| pkt_hdr | input | 1 | Packet header bit for lane 0 |
| pkt_nib1 | input | 4 | Packet nibble for lane 1 |
| pkt_nib2 | input | 4 | Packet nibble for lane 2 |
| lane0_sym | output | 10 | Registered character for lane 0 |
| lane1_sym | output | 10 | Registered character for lane 1 |
| lane2_sym | output | 10 | Registered character for lane 2 |

## Verification
All four sync combinations are swept in idle. This shows that lane 0 follows the syncs in its control code while lanes 1 and 2 stay at code 00. One pass raises both requests together. It shows that video wins the preamble, and it catches a wrong lane-2 preamble code or a wrong guard count. It then drops video while the island request is still held, which shows the immediate video exit and the single separating control clock. Across two packets the island nibbles walk through all sixteen TERC4 inputs on both packet lanes, with header and syncs toggling. The island request drops in the middle of a packet, which separates packet-boundary sampling from sampling on every clock.

// File: rtl/tmds_seq_pkg.sv
package tmds_seq_pkg;

  localparam int SYM_W = 10;
  typedef logic [SYM_W-1:0] sym_t;

  typedef enum logic [2:0] {
    PH_CTRL  = 3'd0,
    PH_PRE_V = 3'd1,
    PH_PRE_I = 3'd2,
    PH_GB_V  = 3'd3,
    PH_VID   = 3'd4,
    PH_GB_IL = 3'd5,
    PH_ISL   = 3'd6,
    PH_GB_IT = 3'd7
  } phase_t;

  localparam sym_t VGB_OUTER = 10'b1011001100;
  localparam sym_t VGB_MID   = 10'b0100110011;
  localparam sym_t IGB_PKT   = 10'b0100110011;

  function automatic sym_t ctl_sym(input logic [1:0] c);
    case (c)
      2'b00:   ctl_sym = 10'b1101010100;
      2'b01:   ctl_sym = 10'b0010101011;
      2'b10:   ctl_sym = 10'b0101010100;
      default: ctl_sym = 10'b1010101011;
    endcase
  endfunction

  function automatic sym_t terc4_sym(input logic [3:0] n);
    case (n)
      4'h0:    terc4_sym = 10'b1010011100;
      4'h1:    terc4_sym = 10'b1001100011;
      4'h2:    terc4_sym = 10'b1011100100;
      4'h3:    terc4_sym = 10'b1011100010;
      4'h4:    terc4_sym = 10'b0101110001;
      4'h5:    terc4_sym = 10'b0100011110;
      4'h6:    terc4_sym = 10'b0110001110;
      4'h7:    terc4_sym = 10'b0100111100;
      4'h8:    terc4_sym = 10'b1011001100;
      4'h9:    terc4_sym = 10'b0100111001;
      4'hA:    terc4_sym = 10'b0110011100;
      4'hB:    terc4_sym = 10'b1011000110;
      4'hC:    terc4_sym = 10'b1010001110;
      4'hD:    terc4_sym = 10'b1001110001;
      4'hE:    terc4_sym = 10'b0101100011;
      default: terc4_sym = 10'b1011000011;
    endcase
  endfunction

endpackage

// File: rtl/tmds_period_fsm.sv
module tmds_period_fsm
  import tmds_seq_pkg::*;
#(
  parameter int PRE_LEN = 8,
  parameter int GB_LEN  = 2,
  parameter int PKT_LEN = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   vid_en,
  input  logic   isl_en,
  output phase_t nxt_ph,
  output logic   nxt_pkt_first,
  output phase_t cur_ph
);

  localparam int MAX_LEN = (PRE_LEN > PKT_LEN) ? ((PRE_LEN > GB_LEN) ? PRE_LEN : GB_LEN)
                                               : ((PKT_LEN > GB_LEN) ? PKT_LEN : GB_LEN);
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] GB_LAST  = CNT_W'(GB_LEN - 1);
  localparam logic [CNT_W-1:0] PKT_LAST = CNT_W'(PKT_LEN - 1);

  phase_t           ph;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt_cnt;

  always_comb begin
    nxt_ph  = ph;
    nxt_cnt = cnt + 1'b1;
    case (ph)
      PH_CTRL: begin
        nxt_cnt = '0;
        if (vid_en)      nxt_ph = PH_PRE_V;
        else if (isl_en) nxt_ph = PH_PRE_I;
      end
      PH_PRE_V: if (cnt == PRE_LAST) begin nxt_ph = PH_GB_V;  nxt_cnt = '0; end
      PH_PRE_I: if (cnt == PRE_LAST) begin nxt_ph = PH_GB_IL; nxt_cnt = '0; end
      PH_GB_V:  if (cnt == GB_LAST)  begin nxt_ph = PH_VID;   nxt_cnt = '0; end
      PH_VID: begin
        nxt_cnt = '0;
        if (!vid_en) nxt_ph = PH_CTRL;
      end
      PH_GB_IL: if (cnt == GB_LAST)  begin nxt_ph = PH_ISL;   nxt_cnt = '0; end
      PH_ISL: if (cnt == PKT_LAST) begin
        nxt_cnt = '0;
        nxt_ph  = isl_en ? PH_ISL : PH_GB_IT;
      end
      PH_GB_IT: if (cnt == GB_LAST)  begin nxt_ph = PH_CTRL;  nxt_cnt = '0; end
      default: begin nxt_ph = PH_CTRL; nxt_cnt = '0; end
    endcase
  end

  assign nxt_pkt_first = (nxt_ph == PH_ISL) && (nxt_cnt == '0);
  assign cur_ph        = ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_CTRL;
      cnt <= '0;
    end else begin
      ph  <= nxt_ph;
      cnt <= nxt_cnt;
    end
  end

  // R6
  vid_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_VID && !vid_en) |=> (ph == PH_CTRL));

  // R6
  pre_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_PRE_V || ph == PH_PRE_I) && cnt == '0) |-> ($past(ph) == PH_CTRL));

  // R3
  pre_len_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_PRE_V || ph == PH_PRE_I) |-> (cnt <= PRE_LAST));

  // R10
  pkt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_ISL && cnt != PKT_LAST) |=> (ph == PH_ISL));

  // R11
  trail_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_GB_IT && cnt == GB_LAST) |=> (ph == PH_CTRL));

endmodule

// File: rtl/tmds_lane_mux.sv
module tmds_lane_mux
  import tmds_seq_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  phase_t     ph,
  input  logic [1:0] ctl_bits,
  input  logic [3:0] nib,
  input  sym_t       vid_sym,
  output sym_t       sym_q
);

  localparam sym_t VGB = (LANE == 1) ? VGB_MID : VGB_OUTER;

  sym_t isl_guard;
  sym_t sym_d;

  generate
    if (LANE == 0) begin : g_sync_lane
      assign isl_guard = terc4_sym(nib);
    end else begin : g_pkt_lane
      assign isl_guard = IGB_PKT;
    end
  endgenerate

  always_comb begin
    case (ph)
      PH_GB_V:            sym_d = VGB;
      PH_VID:             sym_d = vid_sym;
      PH_GB_IL, PH_GB_IT: sym_d = isl_guard;
      PH_ISL:             sym_d = terc4_sym(nib);
      default:            sym_d = ctl_sym(ctl_bits);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sym_q <= ctl_sym(2'b00);
    else     sym_q <= sym_d;
  end

  // R5
  vid_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_VID) |=> (sym_q == $past(vid_sym)));

  // R4
  vgb_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_GB_V) |=> (sym_q == VGB));

  // R8
  igb_chk: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_GB_IL || ph == PH_GB_IT) && LANE != 0) |=> (sym_q == IGB_PKT));

endmodule

// File: rtl/tmds_period_seq.sv
module tmds_period_seq
  import tmds_seq_pkg::*;
#(
  parameter int PRE_LEN = 8,
  parameter int GB_LEN  = 2,
  parameter int PKT_LEN = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vid_en,
  input  logic       isl_en,
  input  logic       hsync,
  input  logic       vsync,
  input  logic [9:0] vid_sym0,
  input  logic [9:0] vid_sym1,
  input  logic [9:0] vid_sym2,
  input  logic       pkt_hdr,
  input  logic [3:0] pkt_nib1,
  input  logic [3:0] pkt_nib2,
  output logic [9:0] lane0_sym,
  output logic [9:0] lane1_sym,
  output logic [9:0] lane2_sym
);

  localparam int LANES = 3;

  phase_t     nxt_ph;
  phase_t     cur_ph;
  logic       nxt_pkt_first;
  logic       in_pre;
  logic       in_guard;
  logic [1:0] ctl_bits [LANES];
  logic [3:0] nib      [LANES];
  sym_t       vsym     [LANES];
  sym_t       lsym     [LANES];

  tmds_period_fsm #(
    .PRE_LEN(PRE_LEN),
    .GB_LEN (GB_LEN),
    .PKT_LEN(PKT_LEN)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .vid_en       (vid_en),
    .isl_en       (isl_en),
    .nxt_ph       (nxt_ph),
    .nxt_pkt_first(nxt_pkt_first),
    .cur_ph       (cur_ph)
  );

  assign in_pre   = (nxt_ph == PH_PRE_V) || (nxt_ph == PH_PRE_I);
  assign in_guard = (nxt_ph == PH_GB_IL) || (nxt_ph == PH_GB_IT);

  assign ctl_bits[0] = {vsync, hsync};
  assign ctl_bits[1] = {1'b0, in_pre};
  assign ctl_bits[2] = {1'b0, nxt_ph == PH_PRE_I};

  assign nib[0] = in_guard ? {2'b11, vsync, hsync}
                           : {~nxt_pkt_first, pkt_hdr, vsync, hsync};
  assign nib[1] = pkt_nib1;
  assign nib[2] = pkt_nib2;

  assign vsym[0] = vid_sym0;
  assign vsym[1] = vid_sym1;
  assign vsym[2] = vid_sym2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tmds_lane_mux #(.LANE(g)) u_mux (
      .clk     (clk),
      .rst     (rst),
      .ph      (nxt_ph),
      .ctl_bits(ctl_bits[g]),
      .nib     (nib[g]),
      .vid_sym (vsym[g]),
      .sym_q   (lsym[g])
    );
  end

  assign lane0_sym = lsym[0];
  assign lane1_sym = lsym[1];
  assign lane2_sym = lsym[2];

  // R2
  ctrl_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == PH_CTRL) |-> (lane1_sym == 10'b1101010100 && lane2_sym == 10'b1101010100));

  // R3
  pre_lane1_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == PH_PRE_V || cur_ph == PH_PRE_I) |-> (lane1_sym == 10'b0010101011));

  // R7
  vid_first_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == PH_CTRL && vid_en) |=> (cur_ph == PH_PRE_V));

endmodule

// File: tb/tmds_period_seq_test.sv
module tmds_period_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vid_en = 1'b0, isl_en = 1'b0, hsync = 1'b0, vsync = 1'b0, pkt_hdr = 1'b0;
  logic [9:0] vid_sym0 = '0, vid_sym1 = '0, vid_sym2 = '0;
  logic [3:0] pkt_nib1 = '0, pkt_nib2 = '0;
  logic [9:0] lane0_sym, lane1_sym, lane2_sym;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tmds_period_seq uut (
    .clk(clk), .rst(rst), .vid_en(vid_en), .isl_en(isl_en),
    .hsync(hsync), .vsync(vsync),
    .vid_sym0(vid_sym0), .vid_sym1(vid_sym1), .vid_sym2(vid_sym2),
    .pkt_hdr(pkt_hdr), .pkt_nib1(pkt_nib1), .pkt_nib2(pkt_nib2),
    .lane0_sym(lane0_sym), .lane1_sym(lane1_sym), .lane2_sym(lane2_sym)
  );

  function automatic logic [9:0] ctl_e(input logic [1:0] c);
    case (c)
      2'b00: return 10'b1101010100;
      2'b01: return 10'b0010101011;
      2'b10: return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [9:0] terc_e(input logic [3:0] n);
    case (n)
      4'h0: return 10'b1010011100;  4'h1: return 10'b1001100011;
      4'h2: return 10'b1011100100;  4'h3: return 10'b1011100010;
      4'h4: return 10'b0101110001;  4'h5: return 10'b0100011110;
      4'h6: return 10'b0110001110;  4'h7: return 10'b0100111100;
      4'h8: return 10'b1011001100;  4'h9: return 10'b0100111001;
      4'hA: return 10'b0110011100;  4'hB: return 10'b1011000110;
      4'hC: return 10'b1010001110;  4'hD: return 10'b1001110001;
      4'hE: return 10'b0101100011;  default: return 10'b1011000011;
    endcase
  endfunction

  task automatic cmp(input logic [9:0] e0, e1, e2, input string req);
    checks++;
    if (lane0_sym !== e0 || lane1_sym !== e1 || lane2_sym !== e2) begin
      fails++;
      $display("FAIL %s: got %b %b %b expected %b %b %b",
               req, lane0_sym, lane1_sym, lane2_sym, e0, e1, e2);
    end
  endtask

  task automatic step(input logic [9:0] e0, e1, e2, input string req);
    @(posedge clk);
    @(negedge clk);
    cmp(e0, e1, e2, req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog: got running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp(10'b1101010100, 10'b1101010100, 10'b1101010100, "R1 reset");
    rst = 1'b0;
    step(10'b1101010100, 10'b1101010100, 10'b1101010100, "R1 after reset");

    // R2: idle sync sweep
    for (int s = 0; s < 4; s++) begin
      hsync = s[0]; vsync = s[1];
      step(ctl_e({vsync, hsync}), ctl_e(2'b00), ctl_e(2'b00), "R2 idle sync");
    end

    // R7: both requests, video wins; R3 video preamble
    vid_en = 1'b1; isl_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hsync = i[0]; vsync = i[1];
      step(ctl_e({vsync, hsync}), ctl_e(2'b01), ctl_e(2'b00), "R3 R7 video preamble");
    end
    // R4
    for (int i = 0; i < 2; i++)
      step(10'b1011001100, 10'b0100110011, 10'b1011001100, "R4 video guard");
    // R5 video pass-through, isl_en ignored (R7)
    for (int i = 0; i < 20; i++) begin
      vid_sym0 = 10'((i * 37 + 5) % 1024);
      vid_sym1 = 10'((i * 113 + 300) % 1024);
      vid_sym2 = 10'((1023 - i * 51) % 1024);
      step(vid_sym0, vid_sym1, vid_sym2, "R5 video data");
    end
    // R6: immediate exit, one plain control clock before the island preamble
    vid_en = 1'b0; hsync = 1'b1; vsync = 1'b0;
    step(ctl_e(2'b01), ctl_e(2'b00), ctl_e(2'b00), "R6 video exit");
    // R3 island preamble
    for (int i = 0; i < 8; i++) begin
      hsync = i[1]; vsync = i[0];
      step(ctl_e({vsync, hsync}), ctl_e(2'b01), ctl_e(2'b01), "R3 island preamble");
    end
    // R8 leading guard
    for (int i = 0; i < 2; i++) begin
      hsync = i[0]; vsync = 1'b1;
      step(terc_e({2'b11, vsync, hsync}), 10'b0100110011, 10'b0100110011, "R8 leading guard");
    end
    // R9 R10: two packets; request dropped in the middle of the second
    for (int i = 0; i < 64; i++) begin
      pkt_nib1 = i[3:0];
      pkt_nib2 = 4'(15 - i[3:0]);
      pkt_hdr = i[1]; hsync = i[2]; vsync = i[3];
      if (i == 40) isl_en = 1'b0;
      step(terc_e({(i % 32) != 0, pkt_hdr, vsync, hsync}), terc_e(pkt_nib1), terc_e(pkt_nib2),
           "R9 R10 island packet");
    end
    // R8 trailing guard
    for (int i = 0; i < 2; i++) begin
      hsync = i[0]; vsync = ~i[0];
      step(terc_e({2'b11, vsync, hsync}), 10'b0100110011, 10'b0100110011, "R8 trailing guard");
    end
    // R11
    hsync = 1'b1; vsync = 1'b1;
    step(ctl_e(2'b11), ctl_e(2'b00), ctl_e(2'b00), "R11 after island");
    step(ctl_e(2'b11), ctl_e(2'b00), ctl_e(2'b00), "R2 idle after island");
    summary();
  end

endmodule